// File: doc/BRIEF.md
# Conversion Queue Sequencer with Debug Freeze

This block steps a converter through two queues of conversion command words (CCWs). Each CCW stands for one conversion. It owns a fixed-latency converter model, keeps the CCW pointer, and starts one conversion at a time. Queue 1 holds CCW slots `0 .. Q2_BASE-1`. Queue 2 holds slots `Q2_BASE .. DEPTH-1`. Each queue is started by a trigger pulse and runs in the way its 2-bit mode register selects.

The block also handles a debug freeze. A breakpoint that arrives while the debug-enable register bit and the external debug-halt flag are both set stops the sequencer. The point at which it stops depends on what the sequencer is doing:
- If no conversion is in progress, it stops at once.
- If a conversion is in progress, it lets that conversion finish first.
- If, while it waits, the active queue's mode is rewritten or queue 2 is aborted, it stops immediately and discards the unfinished conversion.

While frozen, the analog clock enable is low, the interval timer is held in reset and trigger pulses are lost. The register port keeps working. When the freeze is released, execution continues from the saved pointer. If software wrote new modes during the freeze, those modes can send execution to another queue.

Top module: `seq_freeze_ctrl`

## Requirements
- R1: The block freezes only when all three hold: register 0 bit 0 (debug enable) is 1, `dbg_halt` is high, and a `bkpt` pulse arrives. If any one is missing, `frozen` stays 0.
- R2: If no conversion is in progress when the freeze condition arises, `frozen` is high after the very next clock edge.
- R3: If a conversion is in progress, it runs to its `conv_done` pulse, and `frozen` rises on the edge that ends that cycle.
- R4: While the block waits to freeze, a write to the active queue's mode register (address 1 for queue 1, address 2 for queue 2) freezes it on the next edge. The unfinished conversion then gives no `conv_done`, and `ccw_ptr` stays on that CCW.
- R5: A `q2_abort` pulse while the block waits to freeze freezes it on the next edge with no `conv_done`. If queue 2 was the active queue, it is deactivated (status bit 6 reads 0).
- R6: While frozen, `ccw_ptr` holds the CCW that will execute next.
- R7: On release, the active queue resumes at the saved pointer if its mode is nonzero. If its mode is now 00, that queue is dropped and a pending trigger chooses the next queue, queue 1 before queue 2.
- R8: While frozen, `aclk_en` is 0, `pit_rst` is 1 and no `conv_start` occurs. At all other times `aclk_en` is 1 and `pit_rst` is 0.
- R9: Trigger pulses that arrive while frozen are not captured and never start a queue later.
- R10: Register reads and writes work while frozen. Reads are combinational:
  - address 0: debug enable
  - address 1: queue 1 mode
  - address 2: queue 2 mode
  - address 3: status, with bit 7 frozen, bit 6 queue active, bit 5 active queue (1 = queue 2), and the pointer in the low bits
- R11: Once `dbg_halt` is low or the debug-enable bit reads 0, `frozen` drops after the next clock edge.
- R12: `conv_done` pulses exactly `CONV_CYC` cycles after its `conv_start` unless the conversion is cut short.
- R13: Queue behaviour:
  - A trigger starts its queue at the queue's base slot.
  - Mode 01 makes one pass and stops with the pointer back at the base slot.
  - Mode 1x wraps to the base slot and keeps running.
  - Mode 00 disables the queue.
  - Queue 1 goes first when both queues are pending.
  - `q2_abort` stops queue 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Background debug is active |
| bkpt | input | 1 | Breakpoint pulse |
| q1_trig | input | 1 | Trigger pulse for queue 1 |
| q2_trig | input | 1 | Trigger pulse for queue 2 |
| q2_abort | input | 1 | Abort pulse for queue 2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 8 | Register read data |
| conv_start | output | 1 | Starts a conversion of the CCW at `ccw_ptr` |
| conv_done | output | 1 | Conversion finished; a result may be stored |
| ccw_ptr | output | $clog2(DEPTH) | Current or next CCW slot |
| frozen | output | 1 | Sequencer is frozen |
| aclk_en | output | 1 | Analog clock enable |
| pit_rst | output | 1 | Holds the interval timer in reset |

## Verification
The hardest case to reach is a freeze request that is pending while a conversion is still running, followed by a mode rewrite or a queue 2 abort during that same conversion. The stimulus first waits for a `conv_start`, then issues the breakpoint a cycle later so the request is held back. It then writes the mode register, or pulses the abort, a few cycles before the `conv_done` pulse is due. A cycle-level model of the queues, the pointer and the freeze state is compared with the outputs on every clock. It catches a cut conversion that still produces `conv_done`, and a pointer that moves while frozen.

// File: rtl/seq_freeze_ctrl.sv
module seq_freeze_ctrl #(
  parameter int DEPTH    = 8,
  parameter int Q2_BASE  = 4,
  parameter int CONV_CYC = 6,
  localparam int PW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_halt,
  input  logic          bkpt,
  input  logic          q1_trig,
  input  logic          q2_trig,
  input  logic          q2_abort,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [1:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          conv_start,
  output logic          conv_done,
  output logic [PW-1:0] ccw_ptr,
  output logic          frozen,
  output logic          aclk_en,
  output logic          pit_rst
);
  localparam int CW = $clog2(CONV_CYC);

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_FROZEN} st_t;

  st_t           st;
  logic          dbg_en, hold, active, aq, busy, pend1, pend2;
  logic [1:0]    mode1, mode2;
  logic [PW-1:0] ptr;
  logic [CW-1:0] cnt;

  logic       frz_cond, frz_want, mode_hit, q2_kill, cut, cancel, stays_busy;
  logic       can_pick, take1, take2, idle_off;
  logic [1:0] cur_mode;
  logic [PW-1:0] last_ptr, base_ptr;

  assign frz_cond   = dbg_en & dbg_halt;
  assign frz_want   = frz_cond & (hold | bkpt);
  assign cur_mode   = aq ? mode2 : mode1;
  assign last_ptr   = aq ? PW'(DEPTH - 1) : PW'(Q2_BASE - 1);
  assign base_ptr   = aq ? PW'(Q2_BASE) : '0;
  assign mode_hit   = reg_wr & active & (reg_addr == (aq ? 2'd2 : 2'd1));
  assign q2_kill    = q2_abort & active & aq;
  assign cut        = (st == S_DRAIN) & frz_want & (q2_abort | mode_hit);
  assign cancel     = busy & (cut | q2_kill);
  assign conv_done  = busy & (cnt == '0) & ~cancel;
  assign stays_busy = busy & ~conv_done & ~cancel;
  assign conv_start = (st == S_RUN) & ~frz_want & active & ~busy & ~q2_kill & (cur_mode != 2'd0);
  assign idle_off   = (st == S_RUN) & ~frz_want & active & ~busy & (cur_mode == 2'd0);
  assign can_pick   = (st == S_RUN) & ~frz_want & ~active;
  assign take1      = can_pick & pend1 & (mode1 != 2'd0);
  assign take2      = can_pick & ~take1 & pend2 & (mode2 != 2'd0) & ~q2_abort;

  assign frozen  = (st == S_FROZEN);
  assign aclk_en = ~frozen;
  assign pit_rst = frozen;
  assign ccw_ptr = ptr;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {7'd0, dbg_en};
      2'd1:    reg_rdata = {6'd0, mode1};
      2'd2:    reg_rdata = {6'd0, mode2};
      default: reg_rdata = {frozen, active, aq, 5'(ptr)};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN;
      hold <= 1'b0;
      dbg_en <= 1'b0;
      mode1 <= 2'd0;
      mode2 <= 2'd0;
    end else begin
      hold <= frz_want;
      if (!frz_want)            st <= S_RUN;
      else if (st != S_FROZEN)  st <= stays_busy ? S_DRAIN : S_FROZEN;
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    dbg_en <= reg_wdata[0];
          2'd1:    mode1 <= reg_wdata;
          2'd2:    mode2 <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
    end else if (conv_start) begin
      busy <= 1'b1;
      cnt <= CW'(CONV_CYC - 1);
    end else if (cancel || conv_done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1 <= 1'b0;
      pend2 <= 1'b0;
    end else begin
      pend1 <= (pend1 & ~take1) | (q1_trig & ~frozen);
      pend2 <= ((pend2 & ~take2) | (q2_trig & ~frozen)) & ~q2_abort;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      aq <= 1'b0;
      ptr <= '0;
    end else if (q2_kill) begin
      active <= 1'b0;
    end else if (conv_done) begin
      if (ptr == last_ptr) begin
        ptr <= base_ptr;
        active <= cur_mode[1];
      end else begin
        ptr <= ptr + 1'b1;
        active <= (cur_mode != 2'd0);
      end
    end else if (idle_off) begin
      active <= 1'b0;
    end else if (take1) begin
      active <= 1'b1;
      aq <= 1'b0;
      ptr <= '0;
    end else if (take2) begin
      active <= 1'b1;
      aq <= 1'b1;
      ptr <= PW'(Q2_BASE);
    end
  end

  logic [15:0] since_start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          since_start <= '0;
    else if (conv_start) since_start <= 16'd1;
    else if (busy)       since_start <= since_start + 16'd1;
  end

  a_r1_entry_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(dbg_en && dbg_halt));
  a_r2_idle_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && frz_want && !busy) |=> frozen);
  a_r3_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(!busy || conv_done || cancel));
  a_r4_mode_cut_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && frz_want && mode_hit) |-> !conv_done);
  a_r4_mode_cut_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && frz_want && mode_hit) |=> frozen && !busy);
  a_r5_abort_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && frz_want && q2_abort) |=> frozen && !busy);
  a_r6_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(ccw_ptr));
  a_r8_no_activity: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !conv_start && !conv_done && !busy);
  a_r9_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !pend1 && !pend2) |=> !pend1 && !pend2);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !frz_cond) |=> !frozen);
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> since_start == 16'(CONV_CYC));
  a_r13_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (aq ? (ptr >= PW'(Q2_BASE)) : (ptr < PW'(Q2_BASE))));
endmodule

// File: tb/seq_freeze_ctrl_tb.sv
module seq_freeze_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int Q2B   = 4;
  localparam int C     = 6;
  localparam int PW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic dbg_halt = 1'b0, bkpt = 1'b0, q1_trig = 1'b0, q2_trig = 1'b0, q2_abort = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0, reg_wdata = 2'd0;
  logic [7:0] reg_rdata;
  logic conv_start, conv_done, frozen, aclk_en, pit_rst;
  logic [PW-1:0] ccw_ptr;

  seq_freeze_ctrl #(.DEPTH(DEPTH), .Q2_BASE(Q2B), .CONV_CYC(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .bkpt(bkpt), .q1_trig(q1_trig),
    .q2_trig(q2_trig), .q2_abort(q2_abort), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_done(conv_done), .ccw_ptr(ccw_ptr), .frozen(frozen), .aclk_en(aclk_en),
    .pit_rst(pit_rst));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, done_cnt = 0, start_cnt = 0;
  bit finished = 1'b0;

  // behavioural reference: 0 run, 1 waiting, 2 frozen
  int mst = 0, mhold = 0, mdbg = 0, mm1 = 0, mm2 = 0, mact = 0, maq = 0, mptr = 0;
  int mbusy = 0, mleft = 0, mp1 = 0, mp2 = 0, w_mode;
  bit w_want, w_start, w_done, w_cancel, w_kill, w_cut, w_hit, w_t1, w_t2, w_off, w_ok;

  task automatic m_comb();
    w_mode   = maq ? mm2 : mm1;
    w_want   = mdbg != 0 && dbg_halt && (mhold != 0 || bkpt);
    w_hit    = reg_wr && mact != 0 && int'(reg_addr) == (maq != 0 ? 2 : 1);
    w_kill   = q2_abort && mact != 0 && maq != 0;
    w_cut    = mst == 1 && w_want && (q2_abort || w_hit);
    w_cancel = mbusy != 0 && (w_cut || w_kill);
    w_done   = mbusy != 0 && mleft == 0 && !w_cancel;
    w_start  = mst == 0 && !w_want && mact != 0 && mbusy == 0 && !w_kill && w_mode != 0;
    w_off    = mst == 0 && !w_want && mact != 0 && mbusy == 0 && w_mode == 0;
    w_ok     = mst == 0 && !w_want && mact == 0;
    w_t1     = w_ok && mp1 != 0 && mm1 != 0;
    w_t2     = w_ok && !w_t1 && mp2 != 0 && mm2 != 0 && !q2_abort;
  endtask

  function automatic int m_rdata();
    case (reg_addr)
      2'd0: return mdbg;
      2'd1: return mm1;
      2'd2: return mm2;
      default: return (mst == 2 ? 128 : 0) + mact * 64 + maq * 32 + mptr;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (!rst_n) begin
      mst = 0; mhold = 0; mdbg = 0; mm1 = 0; mm2 = 0; mact = 0; maq = 0; mptr = 0;
      mbusy = 0; mleft = 0; mp1 = 0; mp2 = 0;
    end else begin
      int last, base, nst;
      m_comb();
      last = maq != 0 ? DEPTH - 1 : Q2B - 1;
      base = maq != 0 ? Q2B : 0;
      if (!w_want) nst = 0;
      else if (mst == 2) nst = 2;
      else if (mbusy != 0 && !w_done && !w_cancel) nst = 1;
      else nst = 2;
      if (w_kill) mact = 0;
      else if (w_done) begin
        if (mptr == last) begin mptr = base; mact = (w_mode >= 2) ? 1 : 0; end
        else begin mptr = mptr + 1; mact = (w_mode != 0) ? 1 : 0; end
      end else if (w_off) mact = 0;
      else if (w_t1) begin mact = 1; maq = 0; mptr = 0; end
      else if (w_t2) begin mact = 1; maq = 1; mptr = Q2B; end
      if (w_start) begin mbusy = 1; mleft = C - 1; end
      else if (w_cancel || w_done) mbusy = 0;
      else if (mbusy != 0) mleft--;
      if (w_t1) mp1 = 0;
      if (q1_trig && mst != 2) mp1 = 1;
      if (w_t2) mp2 = 0;
      if (q2_trig && mst != 2) mp2 = 1;
      if (q2_abort) mp2 = 0;
      if (reg_wr) begin
        if (reg_addr == 2'd0) mdbg = int'(reg_wdata[0]);
        else if (reg_addr == 2'd1) mm1 = int'(reg_wdata);
        else if (reg_addr == 2'd2) mm2 = int'(reg_wdata);
      end
      mhold = w_want ? 1 : 0;
      mst = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit bad;
      m_comb();
      bad = 1'b0;
      checks++;
      if (conv_start !== w_start) begin bad = 1; $display("FAIL R13 conv_start actual=%0d expected=%0d", conv_start, w_start); end
      if (conv_done !== w_done) begin bad = 1; $display("FAIL R12 conv_done actual=%0d expected=%0d", conv_done, w_done); end
      if (int'(ccw_ptr) != mptr) begin bad = 1; $display("FAIL R6 ccw_ptr actual=%0d expected=%0d", ccw_ptr, mptr); end
      if (frozen !== (mst == 2)) begin bad = 1; $display("FAIL R2 frozen actual=%0d expected=%0d", frozen, mst == 2); end
      if (aclk_en !== (mst != 2) || pit_rst !== (mst == 2)) begin
        bad = 1; $display("FAIL R8 aclk_en/pit_rst actual=%0d/%0d expected=%0d/%0d", aclk_en, pit_rst, mst != 2, mst == 2);
      end
      if (int'(reg_rdata) != m_rdata()) begin bad = 1; $display("FAIL R10 reg_rdata actual=%0d expected=%0d", reg_rdata, m_rdata()); end
      if (bad) fails++;
      if (conv_done) done_cnt++;
      if (conv_start) start_cnt++;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic pulse_bkpt();
    bkpt = 1'b1; tick(); bkpt = 1'b0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (conv_start) return;
      tick();
    end
    chk("R13 conv_start seen", 0, 1);
  endtask

  initial begin
    int n, ps, d0, s0;
    bit seen;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset frozen", frozen, 0);
    chk("R8 reset aclk_en", aclk_en, 1);
    chk("R8 reset pit_rst", pit_rst, 0);
    chk("R13 reset ptr", ccw_ptr, 0);
    tick();

    // single pass of queue 1, latency
    wr(2'd0, 2'd1); wr(2'd1, 2'd1); wr(2'd2, 2'd2);
    d0 = done_cnt;
    q1_trig = 1'b1; tick(); q1_trig = 1'b0;
    wait_start();
    chk("R13 queue1 starts at base", ccw_ptr, 0);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      tick(); n++;
      @(negedge clk);
      if (conv_done) break;
    end
    chk("R12 conversion latency", n, C);
    tick();
    repeat (40) tick();
    reg_addr = 2'd3;
    @(negedge clk);
    chk("R13 single pass stopped", reg_rdata[6], 0);
    chk("R13 ptr back at base", ccw_ptr, 0);
    chk("R13 four conversions", done_cnt - d0, Q2B);
    tick(); reg_addr = 2'd0;

    // priority, then queue 2 abort while running
    q1_trig = 1'b1; q2_trig = 1'b1; tick(); q1_trig = 1'b0; q2_trig = 1'b0;
    wait_start();
    chk("R13 queue1 first", ccw_ptr, 0);
    tick();
    for (int i = 0; i < 20; i++) begin
      wait_start();
      if (int'(ccw_ptr) == Q2B) break;
      tick();
    end
    chk("R13 queue2 follows at base", ccw_ptr, Q2B);
    tick(); tick();
    q2_abort = 1'b1; tick(); q2_abort = 1'b0;
    reg_addr = 2'd3;
    @(negedge clk);
    chk("R13 abort stops queue2", reg_rdata[6], 0);
    tick(); reg_addr = 2'd0;

    // idle freeze, ignored trigger, register access, release
    dbg_halt = 1'b1;
    pulse_bkpt();
    @(negedge clk);
    chk("R2 idle freeze immediate", frozen, 1);
    chk("R8 aclk_en low", aclk_en, 0);
    chk("R8 pit_rst high", pit_rst, 1);
    tick();
    q1_trig = 1'b1; tick(); q1_trig = 1'b0;
    wr(2'd1, 2'd1);
    reg_addr = 2'd1;
    @(negedge clk);
    chk("R10 read while frozen", reg_rdata, 1);
    tick(); reg_addr = 2'd0;
    dbg_halt = 1'b0; tick();
    @(negedge clk);
    chk("R11 release after one edge", frozen, 0);
    s0 = start_cnt;
    tick(); repeat (15) tick();
    chk("R9 trigger during freeze lost", start_cnt - s0, 0);

    // busy freeze waits for completion, resume
    dbg_halt = 1'b1;
    q1_trig = 1'b1; tick(); q1_trig = 1'b0;
    wait_start();
    tick(); tick();
    pulse_bkpt();
    @(negedge clk);
    chk("R3 busy does not freeze yet", frozen, 0);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (frozen) break;
      @(negedge clk);
      if (conv_done) seen = 1'b1;
      tick();
    end
    chk("R3 conversion completed first", seen, 1);
    chk("R3 frozen after done", frozen, 1);
    chk("R6 saved next CCW", ccw_ptr, 1);
    repeat (5) tick();
    @(negedge clk);
    chk("R6 pointer held", ccw_ptr, 1);
    tick();
    dbg_halt = 1'b0; tick();
    wait_start();
    chk("R7 resume at saved pointer", ccw_ptr, 1);
    tick();

    // mode rewrite cuts final conversion, redirect to queue 2
    dbg_halt = 1'b1;
    q2_trig = 1'b1; tick(); q2_trig = 1'b0;
    wait_start();
    ps = int'(ccw_ptr);
    tick();
    pulse_bkpt();
    @(negedge clk);
    chk("R4 waiting, not frozen", frozen, 0);
    d0 = done_cnt;
    tick();
    wr(2'd1, 2'd1);
    @(negedge clk);
    chk("R4 mode write freezes now", frozen, 1);
    chk("R4 pointer stays", ccw_ptr, ps);
    tick();
    wr(2'd1, 2'd0);
    q1_trig = 1'b1; tick(); q1_trig = 1'b0;
    repeat (6) tick();
    chk("R4 no done for cut conversion", done_cnt - d0, 0);
    dbg_halt = 1'b0; tick();
    wait_start();
    chk("R7 new mode redirects to queue2", ccw_ptr, Q2B);
    tick();

    // abort of queue 2 cuts final conversion
    dbg_halt = 1'b1;
    wait_start();
    tick();
    pulse_bkpt();
    @(negedge clk);
    chk("R5 waiting, not frozen", frozen, 0);
    d0 = done_cnt;
    tick();
    q2_abort = 1'b1; tick(); q2_abort = 1'b0;
    reg_addr = 2'd3;
    @(negedge clk);
    chk("R5 abort freezes now", frozen, 1);
    chk("R5 queue2 deactivated", reg_rdata[6], 0);
    chk("R5 no done", done_cnt - d0, 0);
    tick(); reg_addr = 2'd0;
    dbg_halt = 1'b0; tick();
    s0 = start_cnt;
    repeat (20) tick();
    chk("R5 queue2 stays stopped", start_cnt - s0, 0);

    // entry conditions
    pulse_bkpt();
    @(negedge clk);
    chk("R1 no freeze without debug halt", frozen, 0);
    tick();
    dbg_halt = 1'b1;
    wr(2'd0, 2'd0);
    pulse_bkpt();
    @(negedge clk);
    chk("R1 no freeze without enable bit", frozen, 0);
    tick();
    wr(2'd0, 2'd1);
    pulse_bkpt();
    @(negedge clk);
    chk("R1 freeze with all three", frozen, 1);
    tick();
    wr(2'd0, 2'd0);
    @(negedge clk);
    chk("R11 still frozen on write edge", frozen, 1);
    tick();
    @(negedge clk);
    chk("R11 released after enable cleared", frozen, 0);
    tick();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule